// File: doc/BRIEF.md
# Indexed-Access Watchdog Timer

This block is a watchdog peripheral that a host controls through a pair of byte-wide ports. Port offset 0 latches a register index; port offset 1 is a data window onto whichever internal register that index selects. Through this window software enables the counter and programs a 24-bit timeout split across three byte registers. It also selects what an expiry does, issues reload ("kick") commands and inspects or clears a sticky expiry flag.

The counter decrements once per asserted `tick_en`, which the surrounding chip supplies at 32768 Hz. The programmed timeout holds the desired period minus one. If software fails to reload in time, the count reaches zero and the block emits a one-cycle pulse on either the NMI line or the reset line. It then records the event in a flag that survives the resulting reset until software explicitly clears it. After expiring, the counter restarts from the programmed timeout.

Top module: `wdt_indexed`

## Requirements
- R1: A write at port offset 0 stores an 8-bit index, which reads back at offset 0. Reads and writes at offset 1 reach the register selected by the stored index, and reads have no side effects.
- R2: Index 0x37 bit 6 is the counter enable and its other bits read 0. While the enable is 0 the count does not move and no expiry occurs.
- R3: Index 0x38 stores its upper nibble and its lower nibble reads 0. Nibble 0xC routes expiry to `nmi_pulse`, 0xD routes it to `reset_pulse`, and any other value routes it to neither.
- R4: The timeout is held in index 0x39 (bits 7:0), 0x3A (bits 15:8) and 0x3B (bits 23:16), each readable and writable.
- R5: With timeout value N loaded and the counter enabled, expiry happens on the (N+1)-th `tick_en`. The counter then restarts from the timeout and keeps running, so N=0 expires on every tick.
- R6: Writing the enable bit from 0 to 1, or writing 1 to index 0x3C bit 6, loads the counter from the timeout registers. Index 0x3C bit 6 always reads 0, and a load takes precedence over a tick in the same cycle.
- R7: An expiry raises the selected output for exactly one cycle, in the cycle after the clock edge that sampled the expiring tick. The two outputs are never high together.
- R8: Index 0x3C bit 7 is a fired flag, set in the cycle after any expiry pulse (regardless of routing). Writing 0 to it clears it, writing 1 leaves it unchanged, and a set in the same cycle wins over a clear.
- R9: Any index other than 0x37 to 0x3C reads 0x00, and writes to it change no state.
- R10: After reset the index is 0, the counter is disabled, the select nibble, timeout and fired flag are 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one cycle per 32768 Hz tick |
| host_wr | input | 1 | Write strobe for the host port |
| host_addr | input | 1 | Port offset: 0 index, 1 data |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed port (combinational) |
| nmi_pulse | output | 1 | One-cycle expiry pulse routed to NMI |
| reset_pulse | output | 1 | One-cycle expiry pulse routed to system reset |

## Verification
On every cycle the assertions check the following properties. The two outputs are mutually exclusive, and every pulse follows a sampled tick while enabled. A disabled, unloaded counter holds still, and a load yields the programmed timeout. The fired flag rises only after an expiry and falls only on an explicit clearing write. The exact expiry tick count for N and N=0 can only be shown by the bench's scenarios, as can the routing chosen by each select nibble and reload pushing expiry back. The same holds for byte placement of the timeout, the read-as-zero bits and indices, and write-1-no-effect on the flag, all compared against a behavioural model every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DW = 8;
    localparam logic [DW-1:0] IX_CTRL = 8'h37;
    localparam logic [DW-1:0] IX_SEL  = 8'h38;
    localparam logic [DW-1:0] IX_TMO0 = 8'h39;
    localparam logic [DW-1:0] IX_CMD  = 8'h3C;
    localparam int EN_BIT     = 6;
    localparam int RELOAD_BIT = 6;
    localparam int FIRED_BIT  = 7;
    localparam logic [3:0] SEL_NMI = 4'hC;
    localparam logic [3:0] SEL_RST = 4'hD;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_NMI  = 2'd1,
        ACT_RST  = 2'd2
    } act_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             expire_i,
    output logic [DW-1:0]    rdata_o,
    output logic             en_o,
    output act_t             act_o,
    output logic [CNT_W-1:0] tmo_o,
    output logic             load_o
);
    localparam int NB = CNT_W / DW;

    typedef struct packed {
        logic [DW-1:0]    idx;
        logic             en;
        logic [3:0]       sel;
        logic [CNT_W-1:0] tmo;
        logic             fired;
    } regs_t;

    regs_t q, d;
    logic  load_d;
    logic  dwr;

    always_comb begin
        d      = q;
        load_d = 1'b0;
        dwr    = wr_i && addr_i;
        if (wr_i && !addr_i) d.idx = wdata_i;
        if (dwr) begin
            case (q.idx)
                IX_CTRL: begin
                    d.en = wdata_i[EN_BIT];
                    if (wdata_i[EN_BIT] && !q.en) load_d = 1'b1;
                end
                IX_SEL: d.sel = wdata_i[DW-1:DW-4];
                IX_CMD: begin
                    if (wdata_i[RELOAD_BIT]) load_d = 1'b1;
                    if (!wdata_i[FIRED_BIT]) d.fired = 1'b0;
                end
                default: ;
            endcase
        end
        for (int k = 0; k < NB; k++) begin
            if (dwr && q.idx == IX_TMO0 + DW'(k)) d.tmo[k*DW +: DW] = wdata_i;
        end
        if (expire_i) d.fired = 1'b1;
    end

    always_comb begin
        rdata_o = '0;
        if (!addr_i) begin
            rdata_o = q.idx;
        end else begin
            case (q.idx)
                IX_CTRL: rdata_o[EN_BIT]        = q.en;
                IX_SEL:  rdata_o[DW-1:DW-4]     = q.sel;
                IX_CMD:  rdata_o[FIRED_BIT]     = q.fired;
                default: ;
            endcase
            for (int k = 0; k < NB; k++) begin
                if (q.idx == IX_TMO0 + DW'(k)) rdata_o = q.tmo[k*DW +: DW];
            end
        end
    end

    always_comb begin
        case (q.sel)
            SEL_NMI: act_o = ACT_NMI;
            SEL_RST: act_o = ACT_RST;
            default: act_o = ACT_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en_o   = q.en;
    assign tmo_o  = q.tmo;
    assign load_o = load_d;

    // R8
    fired_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.fired) |-> $past(expire_i));
    // R8
    fired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fired && !(wr_i && addr_i && q.idx == IX_CMD && !wdata_i[FIRED_BIT]))
        |=> q.fired);
endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] tmo_i,
    input  act_t             act_i,
    output logic             nmi_o,
    output logic             rst_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             nmi;
        logic             rst;
        logic             exp;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d     = q;
        d.nmi = 1'b0;
        d.rst = 1'b0;
        d.exp = 1'b0;
        if (load_i) begin
            d.cnt = tmo_i;
        end else if (en_i && tick_i) begin
            if (q.cnt == '0) begin
                d.cnt = tmo_i;
                d.exp = 1'b1;
                d.nmi = (act_i == ACT_NMI);
                d.rst = (act_i == ACT_RST);
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign nmi_o    = q.nmi;
    assign rst_o    = q.rst;
    assign expire_o = q.exp;

    // R7
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.nmi && q.rst));
    // R5
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.nmi || q.rst) |-> $past(tick_i && en_i));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> $stable(q.cnt));
    // R6
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q.cnt == $past(tmo_i)));
endmodule

// File: rtl/wdt_indexed.sv
module wdt_indexed
    import wdt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          host_wr,
    input  logic          host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    output logic          nmi_pulse,
    output logic          reset_pulse
);
    logic             en_w;
    logic             load_w;
    logic             expire_w;
    logic [CNT_W-1:0] tmo_w;
    act_t             act_w;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (host_wr),
        .addr_i   (host_addr),
        .wdata_i  (host_wdata),
        .expire_i (expire_w),
        .rdata_o  (host_rdata),
        .en_o     (en_w),
        .act_o    (act_w),
        .tmo_o    (tmo_w),
        .load_o   (load_w)
    );

    wdt_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_en),
        .en_i     (en_w),
        .load_i   (load_w),
        .tmo_i    (tmo_w),
        .act_i    (act_w),
        .nmi_o    (nmi_pulse),
        .rst_o    (reset_pulse),
        .expire_o (expire_w)
    );
endmodule

// File: tb/sim_wdt_indexed.sv
module sim_wdt_indexed;
    localparam int PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       tick_en = 0;
    logic       host_wr = 0;
    logic       host_addr = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       nmi_pulse, reset_pulse;

    int checks = 0, errors = 0;
    int nmi_seen = 0, rst_seen = 0;
    logic [7:0] rv;

    // behavioural model state
    int m_idx = 0, m_en = 0, m_sel = 0, m_tmo = 0, m_fired = 0, m_cnt = 0;
    int m_nmi = 0, m_rst = 0, m_exp = 0;

    always #(PERIOD/2) clk = ~clk;

    wdt_indexed u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .nmi_pulse(nmi_pulse), .reset_pulse(reset_pulse)
    );

    function automatic int model_rd();
        if (host_addr == 0) return m_idx;
        case (m_idx)
            'h37: return m_en ? 'h40 : 0;
            'h38: return m_sel << 4;
            'h39: return m_tmo & 'hFF;
            'h3A: return (m_tmo >> 8) & 'hFF;
            'h3B: return (m_tmo >> 16) & 'hFF;
            'h3C: return m_fired ? 'h80 : 0;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0; m_en = 0; m_sel = 0; m_tmo = 0; m_fired = 0;
            m_cnt = 0; m_nmi = 0; m_rst = 0; m_exp = 0;
        end else begin
            int ld, n_en, n_sel, n_tmo, n_fired, n_idx, w;
            ld = 0; n_en = m_en; n_sel = m_sel; n_tmo = m_tmo;
            n_fired = m_fired; n_idx = m_idx; w = host_wdata;
            if (host_wr && !host_addr) n_idx = w;
            if (host_wr && host_addr) begin
                if (m_idx == 'h37) begin
                    n_en = (w >> 6) & 1;
                    if (n_en && !m_en) ld = 1;
                end else if (m_idx == 'h38) n_sel = w >> 4;
                else if (m_idx == 'h39) n_tmo = (m_tmo & 'hFFFF00) | w;
                else if (m_idx == 'h3A) n_tmo = (m_tmo & 'hFF00FF) | (w << 8);
                else if (m_idx == 'h3B) n_tmo = (m_tmo & 'h00FFFF) | (w << 16);
                else if (m_idx == 'h3C) begin
                    if (w & 'h40) ld = 1;
                    if (!(w & 'h80)) n_fired = 0;
                end
            end
            if (m_exp) n_fired = 1;
            m_nmi = 0; m_rst = 0; m_exp = 0;
            if (ld) m_cnt = m_tmo;
            else if (m_en && tick_en) begin
                if (m_cnt == 0) begin
                    m_cnt = m_tmo; m_exp = 1;
                    m_nmi = (m_sel == 'hC); m_rst = (m_sel == 'hD);
                end else m_cnt = m_cnt - 1;
            end
            m_idx = n_idx; m_en = n_en; m_sel = n_sel; m_tmo = n_tmo; m_fired = n_fired;
        end
    end

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (host_rdata !== 8'(model_rd())) begin
                errors++;
                $display("FAIL R1 rdata actual %0h expected %0h", host_rdata, model_rd());
            end
            checks++;
            if (nmi_pulse !== 1'(m_nmi) || reset_pulse !== 1'(m_rst)) begin
                errors++;
                $display("FAIL R7 nmi/rst actual %0b%0b expected %0b%0b",
                         nmi_pulse, reset_pulse, m_nmi[0], m_rst[0]);
            end
            if (nmi_pulse === 1'b1) nmi_seen++;
            if (reset_pulse === 1'b1) rst_seen++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic port_wr(input logic a, input logic [7:0] d);
        @(negedge clk); #1;
        host_addr = a; host_wdata = d; host_wr = 1;
        @(negedge clk); #1;
        host_wr = 0;
    endtask

    task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
        port_wr(0, ix);
        port_wr(1, d);
    endtask

    task automatic reg_rd(input logic [7:0] ix, output logic [7:0] d);
        port_wr(0, ix);
        @(negedge clk); #1;
        host_addr = 1;
        #1 d = host_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1 tick_en = 1;
            @(negedge clk); #1 tick_en = 0;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R10 reset state
        chk("R10 index", host_rdata, 0);
        reg_rd(8'h37, rv); chk("R10 ctrl", rv, 0);
        reg_rd(8'h3C, rv); chk("R10 fired", rv, 0);
        reg_rd(8'h3B, rv); chk("R10 tmo", rv, 0);
        // R1 index readback
        port_wr(0, 8'h55); #1 chk("R1 index", host_rdata, 8'h55);
        // R4 byte placement
        reg_wr(8'h39, 8'h11); reg_wr(8'h3A, 8'h22); reg_wr(8'h3B, 8'h33);
        reg_rd(8'h39, rv); chk("R4 low", rv, 8'h11);
        reg_rd(8'h3A, rv); chk("R4 mid", rv, 8'h22);
        reg_rd(8'h3B, rv); chk("R4 high", rv, 8'h33);
        reg_wr(8'h39, 8'h03); reg_wr(8'h3A, 8'h00); reg_wr(8'h3B, 8'h00);
        // R3 select nibble storage
        reg_wr(8'h38, 8'hC5); reg_rd(8'h38, rv); chk("R3 sel", rv, 8'hC0);
        // R2 enable bit only
        reg_wr(8'h37, 8'hFF); reg_rd(8'h37, rv); chk("R2 ctrl", rv, 8'h40);
        // R5 N=3 expires on 4th tick
        ticks(3); chk("R5 early", nmi_seen, 0);
        ticks(1); chk("R5 expire", nmi_seen, 1); chk("R7 no rst", rst_seen, 0);
        ticks(4); chk("R5 rerun", nmi_seen, 2);
        // R8 fired flag
        reg_rd(8'h3C, rv); chk("R8 set", rv, 8'h80);
        reg_wr(8'h3C, 8'h80); reg_rd(8'h3C, rv); chk("R8 write1", rv, 8'h80);
        reg_wr(8'h3C, 8'h00); reg_rd(8'h3C, rv); chk("R8 clear", rv, 8'h00);
        // R6 reload command
        ticks(2); reg_wr(8'h3C, 8'h40);
        reg_rd(8'h3C, rv); chk("R6 reload reads 0", rv, 8'h00);
        ticks(3); chk("R6 delayed", nmi_seen, 2);
        ticks(1); chk("R6 expire", nmi_seen, 3);
        // R3 reset routing
        reg_wr(8'h38, 8'hD0); ticks(4);
        chk("R3 reset", rst_seen, 1); chk("R3 no nmi", nmi_seen, 3);
        reg_wr(8'h3C, 8'h00);
        reg_wr(8'h38, 8'h00); ticks(4);
        chk("R3 none nmi", nmi_seen, 3); chk("R3 none rst", rst_seen, 1);
        reg_rd(8'h3C, rv); chk("R8 unrouted", rv, 8'h80);
        // R2 stop and restart
        reg_wr(8'h38, 8'hC0);
        reg_wr(8'h37, 8'h00); ticks(10); chk("R2 stopped", nmi_seen, 3);
        ticks(1); reg_wr(8'h37, 8'h40);
        ticks(3); chk("R6 enable load", nmi_seen, 3);
        ticks(1); chk("R6 enable expire", nmi_seen, 4);
        // R5 boundary N=0
        reg_wr(8'h37, 8'h00); reg_wr(8'h39, 8'h00); reg_wr(8'h37, 8'h40);
        ticks(1); chk("R5 zero a", nmi_seen, 5);
        ticks(1); chk("R5 zero b", nmi_seen, 6);
        // R9 unimplemented indices
        reg_wr(8'h40, 8'hAA); reg_rd(8'h40, rv); chk("R9 read 40", rv, 0);
        reg_wr(8'h36, 8'hFF); reg_rd(8'h36, rv); chk("R9 read 36", rv, 0);
        reg_rd(8'h37, rv); chk("R9 ctrl intact", rv, 8'h40);
        reg_rd(8'h3A, rv); chk("R9 tmo intact", rv, 8'h00);
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule